// File: doc/BRIEF.md
# Accumulating Signed Nibble Calculator

This block is a small two-operand adder for 4-bit two's complement numbers. One group of four switches carries both operands, and one push button acts as the "equal" key. The first accepted press takes the switch value as the first operand and shows it. The second accepted press takes the switch value as the second operand and shows the 4-bit sum. Every later press adds the stored second operand to the running result again. The result wraps within four bits, and an LED marks each step whose addition overflowed.

The raw button is synchronised and debounced inside the block, and a held press counts as one step. The result appears as a signed decimal on two seven-segment positions. The upper position carries a minus sign for negative values and is blank otherwise. The lower position carries the magnitude. A mode-enable input from the surrounding system keeps the calculator from reacting until it is allowed to run.

The sequencer has three states. WAIT_A is entered at reset and waits for the first operand. A press in WAIT_A goes to WAIT_B. WAIT_B waits for the second operand, and a press there goes to ACCUM. ACCUM re-adds the stored second operand on each press and stays in ACCUM until reset.

Top module: `nibble_accum_calc`

## Requirements
- R1: While reset is asserted, and after it is released, both digit outputs are blank (code 0) and the LED is off. The next accepted press is treated as the first operand.
- R2: The first accepted press latches `sw` as operand A and shows its signed value, with the LED at 0.
- R3: The second accepted press latches `sw` as operand B and shows A+B truncated to 4 bits.
- R4: Each further accepted press replaces the result with result+B (4-bit wraparound) using the stored B. Changes on `sw` after B was taken have no effect.
- R5: After each addition, the LED equals the overflow of that addition: both addends have the same sign bit and the sum's sign bit differs. The next addition that does not overflow clears the LED.
- R6: Segment codes are active high, with bit 0 to bit 6 driving segments a to g. Digits 0 to 8 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07 and 7F (hex), the minus sign is 40 and blank is 00. A non-negative result shows blank on `seg_sign` and the digit on `seg_mag`. A negative result shows minus on `seg_sign` and the magnitude on `seg_mag`, with -8 shown as 8.
- R7: While `calc_en` is low, presses change neither the display nor the LED nor the sequencer state.
- R8: A button level counts only after it has stayed unchanged for DEBOUNCE_CYCLES consecutive clock cycles. Shorter pulses are ignored, and one held press gives exactly one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw | input | 4 | Operand switches, two's complement |
| btn_raw | input | 1 | Undebounced "equal" button, active high |
| calc_en | input | 1 | Mode enable; presses are ignored while low |
| seg_sign | output | 7 | Sign digit segments (minus or blank) |
| seg_mag | output | 7 | Magnitude digit segments |
| ovf_led | output | 1 | Overflow of the latest addition |

## Verification
The example chain from -8 with B=3 walks the sum through every wrap point. It separates correct 4-bit truncation from a widened sum, and it tells a per-step overflow flag from a sticky one at the 7+3 to -3 transition. Two negative operands (-8 + -1) check overflow in the negative direction, and 5+2 checks a large sum that does not overflow. Short glitches, long holds and presses while disabled show that only debounced, enabled press edges move the sequencer. A mid-run reset shows that the next press is taken as operand A again.

// File: rtl/nac_pkg.sv
package nac_pkg;

    typedef enum logic [1:0] {
        WAIT_A = 2'd0,
        WAIT_B = 2'd1,
        ACCUM  = 2'd2
    } seq_state_t;

    localparam int NIB_W = 4;
    localparam int SEG_W = 7;

    localparam logic [SEG_W-1:0] SEG_BLANK = 7'h00;
    localparam logic [SEG_W-1:0] SEG_MINUS = 7'h40;

    typedef struct packed {
        logic [NIB_W-1:0] sum;
        logic             ovf;
    } add_res_t;

    function automatic add_res_t nib_add(input logic [NIB_W-1:0] x,
                                         input logic [NIB_W-1:0] y);
        add_res_t r;
        r.sum = x + y;
        r.ovf = (x[NIB_W-1] == y[NIB_W-1]) && (r.sum[NIB_W-1] != x[NIB_W-1]);
        return r;
    endfunction

    function automatic logic [SEG_W-1:0] seg_digit(input logic [NIB_W-1:0] d);
        logic [SEG_W-1:0] s;
        case (d)
            4'd0:    s = 7'h3F;
            4'd1:    s = 7'h06;
            4'd2:    s = 7'h5B;
            4'd3:    s = 7'h4F;
            4'd4:    s = 7'h66;
            4'd5:    s = 7'h6D;
            4'd6:    s = 7'h7D;
            4'd7:    s = 7'h07;
            4'd8:    s = 7'h7F;
            default: s = SEG_BLANK;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/nac_btn_cond.sv
module nac_btn_cond #(
    parameter int DEBOUNCE_CYCLES = 2_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_raw,
    output logic press
);
    localparam int CNT_W = $clog2(DEBOUNCE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(DEBOUNCE_CYCLES - 1);

    logic             sync1, sync2;
    logic             level_q;
    logic [CNT_W-1:0] cnt_q;
    logic             settle;

    // Two-flop synchroniser
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
        end else begin
            sync1 <= btn_raw;
            sync2 <= sync1;
        end
    end

    assign settle = (sync2 != level_q) && (cnt_q == CNT_LIM);

    // Debounce: accept a new level only after it holds for the full window
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= 1'b0;
            cnt_q   <= '0;
        end else if (sync2 == level_q) begin
            cnt_q <= '0;
        end else if (settle) begin
            level_q <= sync2;
            cnt_q   <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Single-cycle pulse on the accepted rising level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) press <= 1'b0;
        else        press <= settle && sync2;
    end

endmodule

// File: rtl/nac_sequencer.sv
module nac_sequencer
    import nac_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [NIB_W-1:0] sw,
    output logic [NIB_W-1:0] result,
    output logic [NIB_W-1:0] opnd_b,
    output logic             shown,
    output logic             ovf
);
    seq_state_t state_q, state_d;
    add_res_t   add_first, add_again;

    assign add_first = nib_add(result, sw);
    assign add_again = nib_add(result, opnd_b);

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WAIT_A;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (step) begin
            unique case (state_q)
                WAIT_A:  state_d = WAIT_B;
                WAIT_B:  state_d = ACCUM;
                ACCUM:   state_d = ACCUM;
                default: state_d = WAIT_A;
            endcase
        end
    end

    // Output / datapath process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result <= '0;
            opnd_b <= '0;
            shown  <= 1'b0;
            ovf    <= 1'b0;
        end else if (step) begin
            unique case (state_q)
                WAIT_A: begin
                    result <= sw;
                    shown  <= 1'b1;
                    ovf    <= 1'b0;
                end
                WAIT_B: begin
                    opnd_b <= sw;
                    result <= add_first.sum;
                    ovf    <= add_first.ovf;
                end
                ACCUM: begin
                    result <= add_again.sum;
                    ovf    <= add_again.ovf;
                end
                default: begin
                    result <= '0;
                    shown  <= 1'b0;
                    ovf    <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/nac_seg_render.sv
module nac_seg_render
    import nac_pkg::*;
(
    input  logic [NIB_W-1:0] result,
    input  logic             shown,
    output logic [SEG_W-1:0] seg_sign,
    output logic [SEG_W-1:0] seg_mag
);
    logic [NIB_W-1:0] mag;

    // Unsigned 4-bit magnitude, so -8 yields 8
    assign mag = result[NIB_W-1] ? (~result + 1'b1) : result;

    always_comb begin
        if (!shown) begin
            seg_sign = SEG_BLANK;
            seg_mag  = SEG_BLANK;
        end else begin
            seg_sign = result[NIB_W-1] ? SEG_MINUS : SEG_BLANK;
            seg_mag  = seg_digit(mag);
        end
    end

endmodule

// File: rtl/nibble_accum_calc.sv
module nibble_accum_calc
    import nac_pkg::*;
#(
    parameter int DEBOUNCE_CYCLES = 2_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] sw,
    input  logic       btn_raw,
    input  logic       calc_en,
    output logic [6:0] seg_sign,
    output logic [6:0] seg_mag,
    output logic       ovf_led
);
    logic             press_pulse;
    logic [NIB_W-1:0] result, opnd_b;
    logic             shown;

    nac_btn_cond #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) u_btn (
        .clk     (clk),
        .rst_n   (rst_n),
        .btn_raw (btn_raw),
        .press   (press_pulse)
    );

    nac_sequencer u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (press_pulse && calc_en),
        .sw     (sw),
        .result (result),
        .opnd_b (opnd_b),
        .shown  (shown),
        .ovf    (ovf_led)
    );

    nac_seg_render u_seg (
        .result   (result),
        .shown    (shown),
        .seg_sign (seg_sign),
        .seg_mag  (seg_mag)
    );

endmodule

// File: rtl/nac_checker.sv
module nac_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       calc_en,
    input logic       press,
    input logic       b_sign,
    input logic [6:0] seg_sign,
    input logic [6:0] seg_mag,
    input logic       ovf_led
);
    p_reset_blank_r1: assert property (@(posedge clk)
        !rst_n |=> (seg_sign == 7'h00 && seg_mag == 7'h00 && !ovf_led));

    p_idle_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !calc_en |=> ($stable(seg_sign) && $stable(seg_mag) && $stable(ovf_led)));

    p_no_press_no_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !press |=> ($stable(seg_sign) && $stable(seg_mag) && $stable(ovf_led)));

    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        press |=> !press);

    // Overflow means the sum's sign departs from the shared addend sign (B's)
    p_overflow_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_led |-> ((seg_sign == 7'h40) != b_sign));

    p_minus_has_mag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_sign == 7'h40) |-> (seg_mag != 7'h00 && seg_mag != 7'h3F));

    p_sign_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_sign == 7'h00 || seg_sign == 7'h40));

endmodule

bind nibble_accum_calc nac_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .calc_en  (calc_en),
    .press    (press_pulse),
    .b_sign   (opnd_b[3]),
    .seg_sign (seg_sign),
    .seg_mag  (seg_mag),
    .ovf_led  (ovf_led)
);

// File: tb/sim_nibble_accum_calc.sv
module sim_nibble_accum_calc;
    localparam int DB = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] sw = 4'd0;
    logic       btn_raw = 1'b0;
    logic       calc_en = 1'b0;
    logic [6:0] seg_sign, seg_mag;
    logic       ovf_led;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    nibble_accum_calc #(.DEBOUNCE_CYCLES(DB)) u0 (
        .clk(clk), .rst_n(rst_n), .sw(sw), .btn_raw(btn_raw),
        .calc_en(calc_en), .seg_sign(seg_sign), .seg_mag(seg_mag),
        .ovf_led(ovf_led)
    );

    // {sw, expected 4-bit value, expected ovf}: chain -8, B=3
    localparam logic [8:0] VEC [8] = '{
        {4'b1000, 4'b1000, 1'b0},
        {4'b0011, 4'b1011, 1'b0},
        {4'b0111, 4'b1110, 1'b0},
        {4'b1111, 4'b0001, 1'b0},
        {4'b0000, 4'b0100, 1'b0},
        {4'b1010, 4'b0111, 1'b0},
        {4'b0101, 4'b1010, 1'b1},
        {4'b1100, 4'b1101, 1'b0}
    };

    function automatic logic [6:0] dig(input int d);
        case (d)
            0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B;
            3: return 7'h4F; 4: return 7'h66; 5: return 7'h6D;
            6: return 7'h7D; 7: return 7'h07; 8: return 7'h7F;
            default: return 7'h00;
        endcase
    endfunction

    // Expected {sign, mag, ovf} for a 4-bit two's complement value
    function automatic logic [14:0] expect_of(input logic [3:0] v, input logic o);
        int s;
        s = v[3] ? int'(v) - 16 : int'(v);
        if (s < 0) return {7'h40, dig(-s), o};
        return {7'h00, dig(s), o};
    endfunction

    task automatic check(input string req, input logic [14:0] exp);
        checks++;
        if ({seg_sign, seg_mag, ovf_led} !== exp) begin
            errors++;
            $display("FAIL %s: got sign=%h mag=%h ovf=%b expected sign=%h mag=%h ovf=%b",
                     req, seg_sign, seg_mag, ovf_led, exp[14:8], exp[7:1], exp[0]);
        end
    endtask

    task automatic press(input int hold);
        @(negedge clk) btn_raw = 1'b1;
        repeat (hold) @(negedge clk);
        btn_raw = 1'b0;
        repeat (3 * DB + 6) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset blank", 15'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 after release", 15'd0);

        // R7: disabled presses ignored
        sw = 4'b0101;
        press(3 * DB);
        check("R7 press while disabled", 15'd0);
        calc_en = 1'b1;

        // R8: short glitch ignored
        @(negedge clk) btn_raw = 1'b1;
        repeat (2) @(negedge clk);
        btn_raw = 1'b0;
        repeat (3 * DB) @(negedge clk);
        check("R8 glitch ignored", 15'd0);

        // Table walk: R2 first, R3 second, R4/R5/R6 after
        for (int i = 0; i < 8; i++) begin
            @(negedge clk) sw = VEC[i][8:5];
            press(2 * DB);
            check(i == 0 ? "R2 operand A" : (i == 1 ? "R3 A+B" : "R4 R5 R6 accumulate"),
                  expect_of(VEC[i][4:1], VEC[i][0]));
        end

        // R7: disable mid-accumulation
        calc_en = 1'b0;
        press(2 * DB);
        check("R7 disabled in ACCUM", expect_of(4'b1101, 1'b0));
        calc_en = 1'b1;

        // R8: long hold gives one step (-3+3=0)
        press(40 * DB);
        check("R8 long hold one step, R6 zero", expect_of(4'b0000, 1'b0));

        // R1: mid-run reset, then R5 negative overflow -8 + -1 = 7
        do_reset();
        check("R1 mid-run reset", 15'd0);
        sw = 4'b1000; press(2 * DB);
        check("R6 minus eight", {7'h40, 7'h7F, 1'b0});
        sw = 4'b1111; press(2 * DB);
        check("R5 negative overflow", expect_of(4'b0111, 1'b1));
        press(2 * DB);
        check("R5 cleared, R4 re-add", expect_of(4'b0110, 1'b0));

        // R3: 5+2 no overflow
        do_reset();
        sw = 4'b0101; press(2 * DB);
        check("R2 positive A", expect_of(4'b0101, 1'b0));
        sw = 4'b0010; press(2 * DB);
        check("R3 5+2", expect_of(4'b0111, 1'b0));

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule